// File: doc/BRIEF.md
# Three-Domain Peripheral Reset Controller

This block holds the reset controls for the peripherals and compute units of a chip. It sits in a 1 KiB window of system registers and is reached over a simple 32-bit word bus. It serves three groups of reset targets, and each group has its own control encoding and its own way of reporting completion.

- **Domain 0** is a single word. Each bit drives one peripheral reset-release line. A second word reports, for each line, the acknowledge returned by the peripheral.
- **Domain 1** gives every heavy compute unit its own word. Bit 0 of that word is a power-down request. Two status bits in the same word change only when the unit acknowledges the transition, which may take tens of milliseconds while a self-test runs.
- **Domain 2** is a single word of reset-release lines with no feedback. One bit of it is a reference-clock select rather than a reset.

Software sets a release bit to let a target run and clears it to hold the target in reset. It then polls the matching status if the domain has one. Bits that name no reset target are not stored and read as zero. Unmapped offsets read as zero and absorb writes without raising an error.

Top module: `rstctl_top`

## Requirements
- R1: After synchronous reset, the domain 0 and domain 2 control words are 0, so every line is held in reset and the clock select is 0. Every unit has its request bit (bit 0) set, its power-down status (bit 27) set and its active status (bit 29) clear.
- R2: A write to byte offset 0x004 stores the write data ANDed with 0x0FFFFFF8. The stored word drives `line0_rel` from the next cycle and reads back from 0x004.
- R3: The word at 0x008 is the `line0_ack` input sampled on each clock and ANDed with 0x0FFFFFF8. It depends only on the acknowledges and not on the control word.
- R4: A write to 0x200 + 4·n, for n from 0 to 12, stores write-data bit 0 as the request bit of unit n and drives it on `unit_pd_req[n]`. All other written bits of that word are ignored.
- R5: In a cycle where `unit_ack[n]` is high, unit n's status takes its current request. A request of 1 sets bit 27 and clears bit 29. A request of 0 sets bit 29 and clears bit 27. Bits 27 and 29 are never both set.
- R6: While `unit_ack[n]` is low, unit n's status bits hold their value, even when its request changes.
- R7: A write to 0x120 stores the write data ANDed with 0x0007FFFF. `line2_rel` carries the stored bits within 0x0007BFFF, and `refclk_sel` carries stored bit 14. The whole stored word reads back.
- R8: Control bits outside a domain's valid set are never stored and read as 0. The valid sets are 0x0FFFFFF8, one request bit per unit, and 0x0007BFFF plus bit 14.
- R9: Any other offset, including a unit index above 12 and any address with bits [1:0] non-zero, reads as 0. A write to such an address changes no state.
- R10: A read request returns `bus_rdata` with `bus_rvalid` high one clock after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| line0_rel | output | 32 | Domain 0 reset-release lines (1 = running) |
| line0_ack | input | 32 | Domain 0 per-line acknowledge from peripherals |
| unit_pd_req | output | 13 | Domain 1 power-down requests per unit |
| unit_ack | input | 13 | Domain 1 per-unit transition acknowledge |
| line2_rel | output | 32 | Domain 2 reset-release lines (1 = running) |
| refclk_sel | output | 1 | Reference clock select from domain 2 bit 14 |

## Verification
Every control word is also an output flop, so a wrong stored bit shows on a reset line on the very next cycle. It shows again at the readback one cycle after a read request. A wrong unit status stays hidden until that unit's word is read. The bench therefore reads unit words after every acknowledge pulse, and also after request changes that arrive without an acknowledge. A domain 0 status fault shows only after the modelled acknowledge delay, so status is read only once the few cycles of that delay have passed.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  // Word indices (byte offset >> 2) inside the 1 KiB window
  localparam int Z0_CTL_IDX = 'h01;
  localparam int Z0_ST_IDX  = 'h02;
  localparam int Z2_IDX     = 'h48;
  localparam int Z1_IDX     = 'h80;
  // Bit positions inside a unit word
  localparam int U_REQ_BIT  = 0;
  localparam int U_PD_BIT   = 27;
  localparam int U_ACT_BIT  = 29;
endpackage

// File: rtl/rstctl_bitreg.sv
module rstctl_bitreg #(
  parameter int          W    = 32,
  parameter logic [31:0] KEEP = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP_W = KEEP[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & KEEP_W;
  end
endmodule

// File: rtl/rstctl_unit.sv
module rstctl_unit (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic wbit,
  input  logic ack,
  output logic req,
  output logic pd_st,
  output logic act_st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b1;
      pd_st  <= 1'b1;
      act_st <= 1'b0;
    end else begin
      if (we) req <= wbit;
      if (ack) begin
        pd_st  <= req;
        act_st <= ~req;
      end
    end
  end
endmodule

// File: rtl/rstctl_rdmux.sv
module rstctl_rdmux
  import rstctl_pkg::*;
#(
  parameter int NUM_UNITS = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_go,
  input  logic                 aligned,
  input  logic [7:0]           widx,
  input  logic [31:0]          z0_ctl,
  input  logic [31:0]          z0_st,
  input  logic [31:0]          z2_ctl,
  input  logic [NUM_UNITS-1:0] req,
  input  logic [NUM_UNITS-1:0] pd_st,
  input  logic [NUM_UNITS-1:0] act_st,
  output logic [31:0]          rdata,
  output logic                 rvalid
);
  logic [31:0] word;

  always_comb begin
    word = '0;
    if (aligned) begin
      if (widx == 8'(Z0_CTL_IDX)) word = z0_ctl;
      if (widx == 8'(Z0_ST_IDX))  word = z0_st;
      if (widx == 8'(Z2_IDX))     word = z2_ctl;
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (widx == 8'(Z1_IDX + u)) begin
          word[U_REQ_BIT] = req[u];
          word[U_PD_BIT]  = pd_st[u];
          word[U_ACT_BIT] = act_st[u];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= word;
    end
  end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int          NUM_UNITS  = 13,
  parameter logic [31:0] MASK0      = 32'h0FFF_FFF8,
  parameter logic [31:0] MASK2      = 32'h0007_BFFF,
  parameter int          REFCLK_BIT = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [9:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [31:0]          line0_rel,
  input  logic [31:0]          line0_ack,
  output logic [NUM_UNITS-1:0] unit_pd_req,
  input  logic [NUM_UNITS-1:0] unit_ack,
  output logic [31:0]          line2_rel,
  output logic                 refclk_sel
);
  localparam logic [31:0] KEEP2 = MASK2 | (32'h1 << REFCLK_BIT);

  logic [7:0]           widx;
  logic                 aligned, wr_go, rd_go;
  logic [31:0]          z0_ctl, z0_st, z2_ctl;
  logic [NUM_UNITS-1:0] req, pd_st, act_st;

  assign widx    = bus_addr[9:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_go   = bus_sel & bus_wr & aligned;
  assign rd_go   = bus_sel & ~bus_wr;

  rstctl_bitreg #(.W(32), .KEEP(MASK0)) u_z0_ctl (
    .clk(clk), .rst(rst), .we(wr_go && widx == 8'(Z0_CTL_IDX)),
    .wdata(bus_wdata), .q(z0_ctl));

  // status mirror samples the acknowledges every cycle
  rstctl_bitreg #(.W(32), .KEEP(MASK0)) u_z0_st (
    .clk(clk), .rst(rst), .we(1'b1), .wdata(line0_ack), .q(z0_st));

  rstctl_bitreg #(.W(32), .KEEP(KEEP2)) u_z2_ctl (
    .clk(clk), .rst(rst), .we(wr_go && widx == 8'(Z2_IDX)),
    .wdata(bus_wdata), .q(z2_ctl));

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    rstctl_unit u_unit (
      .clk(clk), .rst(rst),
      .we(wr_go && widx == 8'(Z1_IDX + g)),
      .wbit(bus_wdata[U_REQ_BIT]),
      .ack(unit_ack[g]),
      .req(req[g]), .pd_st(pd_st[g]), .act_st(act_st[g]));
  end

  rstctl_rdmux #(.NUM_UNITS(NUM_UNITS)) u_rdmux (
    .clk(clk), .rst(rst), .rd_go(rd_go), .aligned(aligned), .widx(widx),
    .z0_ctl(z0_ctl), .z0_st(z0_st), .z2_ctl(z2_ctl),
    .req(req), .pd_st(pd_st), .act_st(act_st),
    .rdata(bus_rdata), .rvalid(bus_rvalid));

  assign line0_rel   = z0_ctl;
  assign line2_rel   = z2_ctl & MASK2;
  assign refclk_sel  = z2_ctl[REFCLK_BIT];
  assign unit_pd_req = req;
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
  parameter int          NUM_UNITS = 13,
  parameter logic [31:0] MASK0     = 32'h0FFF_FFF8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [9:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_rvalid,
  input logic [31:0]          line0_rel,
  input logic [31:0]          line2_rel,
  input logic [NUM_UNITS-1:0] unit_pd_req,
  input logic [NUM_UNITS-1:0] unit_ack,
  input logic [NUM_UNITS-1:0] pd_st,
  input logic [NUM_UNITS-1:0] act_st
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (line0_rel == '0 && line2_rel == '0 && (&unit_pd_req)
                    && (&pd_st) && act_st == '0));

  // R2
  z0_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == 10'h004)
      |=> line0_rel == ($past(bus_wdata) & MASK0));

  // R5
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_st & act_st) == '0);

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_u
    // R6
    hold_status_chk: assert property (@(posedge clk) disable iff (rst)
      !unit_ack[g] |=> ($stable(pd_st[g]) && $stable(act_st[g])));
    // R5
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
      unit_ack[g] |=> (pd_st[g] == $past(unit_pd_req[g])));
  end
endmodule

bind rstctl_top rstctl_chk #(.NUM_UNITS(NUM_UNITS), .MASK0(MASK0)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .line0_rel(line0_rel), .line2_rel(line2_rel), .unit_pd_req(unit_pd_req),
  .unit_ack(unit_ack), .pd_st(pd_st), .act_st(act_st));

// File: tb/tb_rstctl_top.sv
`timescale 1ns/1ps
module tb_rstctl_top;
  localparam int NU = 13;
  localparam logic [31:0] M0 = 32'h0FFF_FFF8;
  localparam logic [31:0] M2 = 32'h0007_BFFF;
  localparam logic [31:0] K2 = 32'h0007_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [31:0] line0_rel, line0_ack, line2_rel;
  logic [NU-1:0] unit_pd_req, unit_ack = '0;
  logic refclk_sel;

  logic follow = 1'b1;
  logic [31:0] forced_ack = '0, rel_d1 = '0, rel_d2 = '0;
  assign line0_ack = follow ? rel_d2 : forced_ack;
  always @(negedge clk) begin
    rel_d1 <= line0_rel;
    rel_d2 <= rel_d1;
  end

  always #4 clk = ~clk;

  rstctl_top dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .line0_rel(line0_rel), .line0_ack(line0_ack),
    .unit_pd_req(unit_pd_req), .unit_ack(unit_ack), .line2_rel(line2_rel),
    .refclk_sel(refclk_sel));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m0, m2;
  logic [NU-1:0] mreq, mpd, mact;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] unit_word(int n);
    logic [31:0] w = '0;
    w[0] = mreq[n]; w[27] = mpd[n]; w[29] = mact[n];
    return w;
  endfunction

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
    check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
  endtask

  task automatic pulse(int n);
    @(negedge clk); unit_ack[n] = 1'b1;
    @(negedge clk); unit_ack[n] = 1'b0;
    mpd[n] = mreq[n]; mact[n] = ~mreq[n];
  endtask

  task automatic check_outs(string tag);
    check({tag, " line0"}, line0_rel, m0);
    check({tag, " line2"}, line2_rel, m2 & M2);
    check({tag, " refclk"}, {31'b0, refclk_sel}, {31'b0, m2[14]});
    check({tag, " pdreq"}, {19'b0, unit_pd_req}, {19'b0, mreq});
  endtask

  task automatic check_reads(string tag);
    logic [31:0] d;
    rd(10'h004, d); check({tag, " rd z0"}, d, m0);
    rd(10'h120, d); check({tag, " rd z2"}, d, m2);
    for (int n = 0; n < NU; n++) begin
      rd(10'(12'h200 + 4 * n), d); check({tag, " rd unit"}, d, unit_word(n));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [9:0] bad [7];
    void'($urandom(32'd20240517));
    bad[0] = 10'h000; bad[1] = 10'h00C; bad[2] = 10'h124; bad[3] = 10'h234;
    bad[4] = 10'h3FC; bad[5] = 10'h005; bad[6] = 10'h202;
    m0 = '0; m2 = '0; mreq = '1; mpd = '1; mact = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check_outs("R1");
    check_reads("R1");

    // R2 / R8 directed: all ones into domain 0
    wr(10'h004, 32'hFFFF_FFFF); m0 = M0;
    check_outs("R2 R8"); rd(10'h004, d); check("R8 z0 mask", d, M0);
    // R3 status follows delayed acks
    repeat (6) @(negedge clk);
    rd(10'h008, d); check("R3 status follow", d, M0);
    follow = 0; forced_ack = 32'h0000_0005; repeat (3) @(negedge clk);
    rd(10'h008, d); check("R3 status from ack only", d, 32'h0);
    forced_ack = 32'hFFFF_FFFF; repeat (3) @(negedge clk);
    wr(10'h004, 32'h0); m0 = '0;
    rd(10'h008, d); check("R3 status independent of ctl", d, M0);
    follow = 1; repeat (6) @(negedge clk);

    // R7 domain 2 incl. clock select
    wr(10'h120, 32'hFFFF_FFFF); m2 = K2;
    check_outs("R7"); rd(10'h120, d); check("R7 rd z2", d, K2);
    wr(10'h120, 32'h0000_4000); m2 = 32'h4000;
    check_outs("R7 refclk only");

    // R4 / R5 / R6 unit 0 and unit 12
    wr(10'h200, 32'hFFFF_FFFE); mreq[0] = 0;
    check_outs("R4 bit0 only");
    rd(10'h200, d); check("R6 no ack keeps status", d, unit_word(0));
    pulse(0); rd(10'h200, d); check("R5 release ack", d, 32'h2000_0000);
    wr(10'h230, 32'h0); mreq[12] = 0; pulse(12);
    rd(10'h230, d); check("R5 unit12 active", d, unit_word(12));
    wr(10'h230, 32'h1); mreq[12] = 1;
    rd(10'h230, d); check("R6 unit12 pending", d, 32'h2000_0001);
    pulse(12); rd(10'h230, d); check("R5 unit12 powered down", d, 32'h0800_0001);

    // R9 unmapped accesses
    for (int i = 0; i < 7; i++) begin
      wr(bad[i], 32'hFFFF_FFFF);
      rd(bad[i], d); check("R9 unmapped read", d, 32'h0);
    end
    check_outs("R9"); check_reads("R9");

    // random mix
    for (int it = 0; it < 120; it++) begin
      int k = $urandom % 6;
      int n = $urandom % NU;
      logic [31:0] r = $urandom;
      case (k)
        0: begin wr(10'h004, r); m0 = r & M0; end
        1: begin wr(10'h120, r); m2 = r & K2; end
        2: begin wr(10'(12'h200 + 4 * n), r); mreq[n] = r[0]; end
        3: pulse(n);
        4: wr(bad[$urandom % 7], r);
        default: begin
          rd(10'(12'h200 + 4 * n), d); check("R5 R6 rand unit", d, unit_word(n));
        end
      endcase
      check_outs("R2 R4 R7 rand");
      if (it % 20 == 19) begin
        repeat (6) @(negedge clk);
        rd(10'h008, d); check("R3 rand status", d, m0);
        check_reads("R8 rand");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule